// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a serial-bus master that runs one complete conversion on a 12-bit successive-approximation converter with a four-wire serial port. The bus runs with the clock idling low and data sampled on the rising edge. When the block receives a start request, it pulls chip select low. It then shifts out a configuration byte built from the requested channel code and mode bits, followed by two all-zero bytes. While those bytes go out, it shifts in the converter's reply, and at the end it releases chip select. The reply received during the configuration byte is thrown away. The two later bytes carry one leading pad bit, the 12 result bits MSB first, and three trailing pad bits. Only the 12 result bits are kept, and they are presented with a one-cycle valid pulse.

The serial clock is derived from the system clock by a programmable half-period count. That count is latched when a frame is admitted. The whole frame must fit within 120 µs, and the serial clock must not exceed 2 MHz. A start request whose divider setting breaks either bound is refused with a one-cycle error pulse.

The sequencer has five states, and every transition fires on the end of a half period:
- IDLE to SETUP when a start request is admitted.
- SETUP to HIGH.
- HIGH to LOW.
- LOW back to HIGH while bits remain.
- LOW to GAP after the 24th bit.
- GAP to IDLE after two half periods.

Top module: `adc_seq_master`

## Requirements
- R1: While reset is held, chip select is high, the serial clock, data out, busy, rate error and result valid are low.
- R2: The 24 bits sent on mosi, MSB first, are the configuration byte {1, chan_sel[2:0], unipolar, single_ended, 1, 1} followed by 16 zero bits.
- R3: The serial clock idles low and rises only while chip select is low. Mosi changes only when the serial clock falls, or when chip select falls. Miso is sampled when the serial clock rises.
- R4: Every serial-clock half period, and the setup time before the first rising edge, lasts half_div system cycles. Chip select stays low for exactly 49·half_div cycles, during which there are exactly 24 rising edges.
- R5: result_data is taken from received bits 10 to 21, counting the first received bit as 1, with the first of these as MSB. The first received byte, the leading pad bit and the trailing pad bits have no effect on it.
- R6: result_valid is high for exactly one cycle, the cycle in which chip select returns high. result_data keeps its value until the next valid pulse.
- R7: A start request in IDLE is admitted only if half_div ≥ ceil(CLK_KHZ/4000) and 49·half_div ≤ CLK_KHZ·120/1000. Otherwise rate_err pulses for one cycle and no frame starts.
- R8: Start requests are honoured only in IDLE, and busy is high in every other state. With start held high, chip select stays high for 2·half_div+1 cycles between frames.
- R9: half_div is latched at admission, so changing it during a frame has no effect on that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request a conversion frame |
| chan_sel | input | 3 | Channel code placed in the configuration byte |
| unipolar | input | 1 | 1 = unipolar coding, 0 = bipolar |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| half_div | input | DIV_W | System cycles per serial-clock half period |
| busy | output | 1 | Sequencer outside IDLE |
| rate_err | output | 1 | One-cycle pulse: start refused for divider setting |
| result_valid | output | 1 | One-cycle pulse: new result available |
| result_data | output | 12 | Conversion result |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with CLK_KHZ = 8000 and DIV_W = 5. With those values the admission window is half_div 2 to 19, and the full 5-bit divider range 0 to 31 can be swept. That sweep exercises both refusal edges and runs a complete frame at every legal rate. The short frames at half_div 2 also allow all 32 combinations of channel code and mode bits to be run, each with a computed result pattern. Garbage is driven in the first reply byte and in the pad bits, so that wrong extraction positions show up. Held-start back-to-back frames and mid-frame divider changes are covered as well.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_HIGH,
        S_LOW,
        S_GAP
    } seq_state_t;

    localparam int CFG_BITS   = 8;
    localparam int ZERO_BYTES = 2;
    localparam int FRAME_BITS = CFG_BITS * (1 + ZERO_BYTES);
    localparam int RES_BITS   = 12;
    localparam int LEAD_PAD   = 1;
    localparam int DATA_FIRST = CFG_BITS + LEAD_PAD;
    localparam int DATA_LAST  = DATA_FIRST + RES_BITS - 1;
    localparam int HALVES_LOW = 2 * FRAME_BITS + 1;

    function automatic logic [CFG_BITS-1:0] make_cfg(
        input logic [2:0] sel,
        input logic       unip,
        input logic       single
    );
        return {1'b1, sel, unip, single, 2'b11};
    endfunction

endpackage

// File: rtl/adc_seq_halfcnt.sv
module adc_seq_halfcnt #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == DIV_W'(half_len - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int TX_BITS = 24,
    parameter int RX_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TX_BITS-1:0] load_word,
    input  logic               advance,
    input  logic               capture,
    input  logic               miso,
    output logic               mosi,
    output logic [RX_BITS-1:0] rx_word
);
    logic [TX_BITS-1:0] tx_q;
    logic [RX_BITS-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (advance) begin
            tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[RX_BITS-2:0], miso};
        end
    end

    assign mosi    = tx_q[TX_BITS-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
    import adc_seq_pkg::*;
#(
    parameter int CLK_KHZ = 250000,
    parameter int DIV_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic [2:0]          chan_sel,
    input  logic                unipolar,
    input  logic                single_ended,
    input  logic [DIV_W-1:0]    half_div,
    output logic                busy,
    output logic                rate_err,
    output logic                result_valid,
    output logic [RES_BITS-1:0] result_data,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso
);
    localparam int MIN_HALF  = (CLK_KHZ + 3999) / 4000;
    localparam int LIMIT_CYC = CLK_KHZ * 120 / 1000;
    localparam int IDX_W     = $clog2(FRAME_BITS + 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] bit_cnt_q;
    logic             gap_half_q;
    logic [DIV_W-1:0] div_q;

    logic             tick;
    logic             accept, reject, load, advance, capture, cap_data;
    logic             last_bit;
    logic [IDX_W-1:0] next_idx;
    logic [31:0]      frame_cyc;
    logic             rate_ok;
    logic [RES_BITS-1:0] rx_word;
    logic             sclk_q, cs_n_q, valid_q, err_q;
    logic [RES_BITS-1:0] result_q;

    // admission check on the requested divider
    assign frame_cyc = 32'(half_div) * 32'(HALVES_LOW);
    assign rate_ok   = (32'(half_div) >= 32'(MIN_HALF)) &&
                       (frame_cyc <= 32'(LIMIT_CYC));

    assign last_bit = (bit_cnt_q == IDX_W'(FRAME_BITS - 1));
    assign next_idx = (state_q == S_SETUP) ? '0 : IDX_W'(bit_cnt_q + 1'b1);
    assign cap_data = capture &&
                      (next_idx >= IDX_W'(DATA_FIRST)) &&
                      (next_idx <= IDX_W'(DATA_LAST));

    adc_seq_halfcnt #(
        .DIV_W (DIV_W)
    ) u_halfcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != S_IDLE),
        .half_len (div_q),
        .tick     (tick)
    );

    adc_seq_shift #(
        .TX_BITS (FRAME_BITS),
        .RX_BITS (RES_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word ({make_cfg(chan_sel, unipolar, single_ended),
                     {(FRAME_BITS - CFG_BITS){1'b0}}}),
        .advance   (advance),
        .capture   (cap_data),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        reject  = 1'b0;
        load    = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_req) begin
                    if (rate_ok) begin
                        accept  = 1'b1;
                        load    = 1'b1;
                        state_d = S_SETUP;
                    end else begin
                        reject  = 1'b1;
                    end
                end
            end
            S_SETUP: begin
                if (tick) begin
                    capture = 1'b1;
                    state_d = S_HIGH;
                end
            end
            S_HIGH: begin
                if (tick) begin
                    advance = 1'b1;
                    state_d = S_LOW;
                end
            end
            S_LOW: begin
                if (tick) begin
                    if (last_bit) begin
                        state_d = S_GAP;
                    end else begin
                        capture = 1'b1;
                        state_d = S_HIGH;
                    end
                end
            end
            S_GAP: begin
                if (tick && gap_half_q) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            bit_cnt_q  <= '0;
            gap_half_q <= 1'b0;
            div_q      <= DIV_W'(1);
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_cnt_q <= '0;
                div_q     <= half_div;
            end else if (state_q == S_LOW && state_d == S_HIGH) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (state_q != S_GAP) begin
                gap_half_q <= 1'b0;
            end else if (tick) begin
                gap_half_q <= ~gap_half_q;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            sclk_q  <= (state_d == S_HIGH);
            cs_n_q  <= !(state_d == S_SETUP || state_d == S_HIGH ||
                         state_d == S_LOW);
            err_q   <= reject;
            valid_q <= (state_q == S_LOW) && (state_d == S_GAP);
            if ((state_q == S_LOW) && (state_d == S_GAP)) begin
                result_q <= rx_word;
            end
        end
    end

    assign busy         = (state_q != S_IDLE);
    assign rate_err     = err_q;
    assign result_valid = valid_q;
    assign result_data  = result_q;
    assign sclk         = sclk_q;
    assign cs_n         = cs_n_q;
endmodule

// File: rtl/adc_seq_master_chk.sv
module adc_seq_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic busy,
    input logic rate_err,
    input logic result_valid,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);
    logic       sclk_prev, cs_prev;
    logic [5:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            cs_prev   <= cs_n;
            if (!cs_n && sclk && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end else if (cs_n && cs_prev) begin
                rise_cnt <= '0;
            end
        end
    end

    a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    a_r3_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_prev) |-> (rise_cnt == 6'd24));

    a_r6_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && !cs_prev));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r7_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> (cs_n && !busy));

    a_r8_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(start_req) && !$past(busy)));
endmodule

bind adc_seq_master adc_seq_master_chk u_adc_seq_master_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .busy         (busy),
    .rate_err     (rate_err),
    .result_valid (result_valid),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi)
);

// File: tb/adc_seq_master_bench.sv
module adc_seq_master_bench;
    localparam int B_KHZ = 8000;
    localparam int B_DW  = 5;
    localparam int MINH  = (B_KHZ + 3999) / 4000;
    localparam int LIM   = B_KHZ * 120 / 1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            start_req = 1'b0;
    logic [2:0]      chan_sel = '0;
    logic            unipolar = 1'b0;
    logic            single_ended = 1'b0;
    logic [B_DW-1:0] half_div = B_DW'(2);
    logic            busy, rate_err, result_valid, sclk, cs_n, mosi;
    logic            miso = 1'b0;
    logic [11:0]     result_data;

    adc_seq_master #(.CLK_KHZ(B_KHZ), .DIV_W(B_DW)) u_adc_seq_master (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .chan_sel(chan_sel),
        .unipolar(unipolar), .single_ended(single_ended), .half_div(half_div),
        .busy(busy), .rate_err(rate_err), .result_valid(result_valid),
        .result_data(result_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // converter model: reply word shifted out on falling serial clock
    logic [23:0] s_word = '0;
    logic [23:0] s_sh;
    always @(negedge cs_n) begin
        s_sh = s_word;
        miso = s_sh[23];
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            s_sh = {s_sh[22:0], 1'b0};
            miso = s_sh[23];
        end
    end

    // bus monitor sampled on the system clock
    logic [23:0] cap = '0;
    int rises = 0, low_cnt = 0, hi_cnt = 0, last_gap = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    always @(posedge clk) begin
        prev_cs   <= cs_n;
        prev_sclk <= sclk;
        if (!cs_n && prev_cs) begin
            low_cnt  <= 1;
            cap      <= '0;
            rises    <= 0;
            last_gap <= hi_cnt;
            hi_cnt   <= 0;
        end else begin
            if (!cs_n) low_cnt <= low_cnt + 1;
            else       hi_cnt  <= hi_cnt + 1;
            if (sclk && !prev_sclk) begin
                cap   <= {cap[22:0], mosi};
                rises <= rises + 1;
            end
        end
    end

    task automatic wait_valid(output bit seen);
        int t = 0;
        while (!result_valid && t < 5000) begin
            @(negedge clk);
            t++;
        end
        seen = result_valid;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_frame(input logic [2:0] sel, input bit uni, input bit sgl,
                             input int h, input logic [11:0] data,
                             input logic [7:0] junk, input bit move_div);
        bit seen;
        logic [23:0] exp_tx;
        exp_tx = {1'b1, sel, uni, sgl, 2'b11, 16'h0000};
        @(negedge clk);
        chan_sel = sel; unipolar = uni; single_ended = sgl;
        half_div = B_DW'(h);
        s_word = {junk, 1'b1, data, 3'b111};
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk(!cs_n && busy, "R8 frame admitted in IDLE", {cs_n, busy}, 1);
        if (move_div) half_div = B_DW'((h == 2) ? 7 : 2);
        wait_valid(seen);
        chk(seen, "R6 valid pulse", seen, 1);
        chk(result_data == data, "R5 result extraction", result_data, data);
        chk(cap == exp_tx, "R2 transmitted bits", cap, exp_tx);
        chk(low_cnt == 49 * h, "R4 R9 chip-select low span", low_cnt, 49 * h);
        chk(rises == 24, "R4 rising edge count", rises, 24);
        chk(cs_n && !sclk, "R6 chip select high with valid", {cs_n, sclk}, 2);
        @(negedge clk);
        chk(!result_valid, "R6 valid lasts one cycle", result_valid, 0);
        chk(result_data == data, "R6 result held", result_data, data);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !mosi && !busy && !rate_err && !result_valid,
            "R1 reset outputs", {cs_n, sclk, mosi, busy, rate_err, result_valid}, 6'b100000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R5: every channel code and mode combination
        for (int i = 0; i < 32; i++) begin
            run_frame(3'(i >> 2), i[1], i[0], 2, 12'((i * 389 + 1443) & 12'hFFF),
                      8'(8'hA5 ^ i), 1'b0);
        end
        run_frame(3'd0, 1'b1, 1'b1, 2, 12'h000, 8'hFF, 1'b0);
        run_frame(3'd7, 1'b0, 1'b0, 2, 12'hFFF, 8'h00, 1'b0);

        // R7: divider sweep over the whole input range
        for (int h = 0; h < 32; h++) begin
            bit ok;
            ok = (h >= MINH) && (49 * h <= LIM);
            @(negedge clk);
            half_div = B_DW'(h);
            chan_sel = 3'(h); unipolar = 1'b1; single_ended = 1'b0;
            s_word = {8'h3C, 1'b1, 12'((h * 97) & 12'hFFF), 3'b111};
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
            chk(rate_err == !ok, "R7 refusal flag", rate_err, !ok);
            chk(cs_n == !ok, "R7 frame launch", cs_n, !ok);
            if (ok) begin
                wait_valid(seen);
                chk(seen && result_data == 12'((h * 97) & 12'hFFF), "R7 R4 frame at rate",
                    result_data, (h * 97) & 12'hFFF);
                chk(low_cnt == 49 * h, "R4 span at rate", low_cnt, 49 * h);
                wait_idle();
            end else begin
                @(negedge clk);
                chk(!rate_err && cs_n, "R7 refusal one cycle", {rate_err, cs_n}, 1);
            end
        end

        // R9: divider change during a frame
        run_frame(3'd5, 1'b0, 1'b1, 2, 12'h5A5, 8'h81, 1'b1);
        run_frame(3'd2, 1'b1, 1'b0, 6, 12'h3C3, 8'h7E, 1'b1);

        // R8: start held high, back-to-back frames
        @(negedge clk);
        half_div = B_DW'(3);
        chan_sel = 3'd1; unipolar = 1'b0; single_ended = 1'b1;
        s_word = {8'hC3, 1'b1, 12'h9B4, 3'b111};
        start_req = 1'b1;
        wait_valid(seen);
        chk(seen && result_data == 12'h9B4, "R8 first of pair", result_data, 12'h9B4);
        @(negedge clk);
        chk(busy && cs_n, "R8 busy during gap", {busy, cs_n}, 3);
        begin
            int t = 0;
            while (cs_n && t < 100) begin
                @(negedge clk);
                t++;
            end
        end
        @(negedge clk);
        start_req = 1'b0;
        chk(last_gap == 2 * 3 + 1, "R8 chip-select gap", last_gap, 7);
        wait_valid(seen);
        chk(seen && result_data == 12'h9B4, "R8 second of pair", result_data, 12'h9B4);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(cs_n && !busy, "R8 no third frame", {cs_n, busy}, 2);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule